// File: doc/BRIEF.md
# DMA Channel Address and Count Engine

This block is the per-channel transfer engine of an ISA-style DMA controller. Software-side programming is reduced to a single load strobe, which captures a 16-bit start address, a 16-bit count, an 8-bit page value and three configuration bits. The configuration bits select word or byte transfers, automatic reload, and a downward address direction. Each pulse on the step input stands for one completed bus cycle. On that pulse the engine advances its current address by one and lowers its current count by one.

The physical address is built from the page and the current address. In byte mode the window is 64K bytes; in word mode it is 128K bytes. The page never takes a carry or a borrow from the address, so a run that reaches the end of its window wraps back to the start of the same window. The count holds one less than the number of transfers. The terminal step is the one on which the count passes from 0x0000 to 0xFFFF. On that step the engine either stops or, when automatic reload is set, restores the programmed address and count.

Top module: `dma_chan_engine`

## Requirements
- R1: After reset, active is 0, termCount is 0, curCount is 0x0000 and physAddr is 0x000000.
- R2: A load cycle copies the start address and count into the current registers, captures the page and mode bits, and sets active to 1 from the next cycle. termCount is 0 in the cycle after a load.
- R3: In byte mode (wordMode=0), physAddr[23:16] is the page and physAddr[15:0] is the current address.
- R4: In word mode (wordMode=1), physAddr[23:17] is page[7:1], physAddr[16:1] is the current address and physAddr[0] is 0. Page bit 0 has no effect.
- R5: A step while active adds one to the current address and subtracts one from curCount. A step while not active leaves curCount and physAddr unchanged.
- R6: With addrDown=1, each step subtracts one from the current address instead of adding one.
- R7: The address wraps within its window (0xFFFF to 0x0000 going up, 0x0000 to 0xFFFF going down) and the page bits of physAddr do not change.
- R8: On the step where curCount goes from 0x0000 to 0xFFFF without automatic reload, termCount is 1 for the following cycle only, active goes to 0, and curCount then reads 0xFFFF.
- R9: With autoInit=1, the terminal step pulses termCount and reloads the current address and count from the loaded values, and active stays 1.
- R10: A load in the same cycle as a step takes priority, and the step has no effect.
- R11: A loaded count of 0x0000 gives exactly one transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| load | input | 1 | Program strobe: capture start values and configuration |
| baseAddr | input | 16 | Start address within the window |
| baseCount | input | 16 | Transfer count minus one |
| pageIn | input | 8 | Page value forming the high physical bits |
| wordMode | input | 1 | 1 = 16-bit transfers (128K window), 0 = byte transfers |
| autoInit | input | 1 | Reload start values at terminal count |
| addrDown | input | 1 | 1 = address steps down |
| step | input | 1 | One completed transfer cycle |
| physAddr | output | 24 | Physical address of the current transfer |
| curCount | output | 16 | Current remaining count minus one |
| active | output | 1 | Channel enabled and accepting steps |
| termCount | output | 1 | One-cycle pulse after the terminal step |

## Verification
The bench targets window wrap in both directions and in both modes. A design that carried into the page would move physAddr into the next 64K or 128K window. Counts of zero and one are used to confirm the off-by-one rule: a wrong design would stop one step early or one step late, or would read 0x0000 instead of 0xFFFF at the end. The bench also covers steps after termination, auto-reload, and a load coinciding with a step. These show up a channel that keeps counting after it stops, loses its start values on reload, or lets the step corrupt freshly loaded values.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
  typedef struct packed {
    logic loadBase;
    logic advance;
    logic reload;
  } chanCtlT;
endpackage

// File: rtl/dma_chan_path.sv
module dma_chan_path
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  chanCtlT           ctl,
  input  logic [ADDR_W-1:0] baseAddrIn,
  input  logic [ADDR_W-1:0] baseCountIn,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic              wordModeIn,
  input  logic              addrDownIn,
  output logic [PHYS_W-1:0] physAddr,
  output logic [ADDR_W-1:0] curCount,
  output logic              countZero
);
  logic [ADDR_W-1:0] baseAddrQ, baseCountQ, curAddrQ, curCountQ;
  logic [PAGE_W-1:0] pageQ;
  logic              wordQ, downQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseAddrQ  <= '0;
      baseCountQ <= '0;
      curAddrQ   <= '0;
      curCountQ  <= '0;
      pageQ      <= '0;
      wordQ      <= 1'b0;
      downQ      <= 1'b0;
    end else if (ctl.loadBase) begin
      baseAddrQ  <= baseAddrIn;
      baseCountQ <= baseCountIn;
      curAddrQ   <= baseAddrIn;
      curCountQ  <= baseCountIn;
      pageQ      <= pageIn;
      wordQ      <= wordModeIn;
      downQ      <= addrDownIn;
    end else if (ctl.reload) begin
      curAddrQ  <= baseAddrQ;
      curCountQ <= baseCountQ;
    end else if (ctl.advance) begin
      curAddrQ  <= downQ ? curAddrQ - 1'b1 : curAddrQ + 1'b1;
      curCountQ <= curCountQ - 1'b1;
    end
  end

  always_comb begin
    if (wordQ) physAddr = {pageQ[PAGE_W-1:1], curAddrQ, 1'b0};
    else       physAddr = {pageQ, curAddrQ};
  end

  assign curCount  = curCountQ;
  assign countZero = (curCountQ == '0);

  assert_hold_idle_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!ctl.advance && !ctl.loadBase && !ctl.reload) |=> ($stable(curCountQ) && $stable(curAddrQ)));

  assert_page_fixed_R7: assert property (@(posedge clk) disable iff (!rstN)
    !ctl.loadBase |=> ($stable(pageQ) && $stable(wordQ)));

  assert_reload_base_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.reload && !ctl.loadBase) |=> (curCountQ == baseCountQ && curAddrQ == baseAddrQ));
endmodule

// File: rtl/dma_chan_ctrl.sv
module dma_chan_ctrl
  import dma_chan_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    load,
  input  logic    step,
  input  logic    autoInitIn,
  input  logic    countZero,
  output chanCtlT ctl,
  output logic    active,
  output logic    termCount
);
  logic activeQ, autoQ, tcQ, lastStep;

  assign lastStep     = ctl.advance && countZero;
  assign ctl.loadBase = load;
  assign ctl.advance  = step && activeQ && !load;
  assign ctl.reload   = lastStep && autoQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      autoQ   <= 1'b0;
      tcQ     <= 1'b0;
    end else if (load) begin
      activeQ <= 1'b1;
      autoQ   <= autoInitIn;
      tcQ     <= 1'b0;
    end else begin
      tcQ <= lastStep;
      if (lastStep && !autoQ) activeQ <= 1'b0;
    end
  end

  assign active    = activeQ;
  assign termCount = tcQ;

  assert_tc_needs_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    termCount |-> $past(step));

  assert_stop_flags_tc_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(active) |-> termCount);

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rstN)
    load |=> (active && !termCount));
endmodule

// File: rtl/dma_chan_engine.sv
module dma_chan_engine
  import dma_chan_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int PAGE_W = 8,
  localparam int PHYS_W = ADDR_W + PAGE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              load,
  input  logic [ADDR_W-1:0] baseAddr,
  input  logic [ADDR_W-1:0] baseCount,
  input  logic [PAGE_W-1:0] pageIn,
  input  logic              wordMode,
  input  logic              autoInit,
  input  logic              addrDown,
  input  logic              step,
  output logic [PHYS_W-1:0] physAddr,
  output logic [ADDR_W-1:0] curCount,
  output logic              active,
  output logic              termCount
);
  chanCtlT ctl;
  logic    countZero;

  dma_chan_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .load(load), .step(step),
    .autoInitIn(autoInit), .countZero(countZero),
    .ctl(ctl), .active(active), .termCount(termCount)
  );

  dma_chan_path #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) uPath (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .baseAddrIn(baseAddr), .baseCountIn(baseCount), .pageIn(pageIn),
    .wordModeIn(wordMode), .addrDownIn(addrDown),
    .physAddr(physAddr), .curCount(curCount), .countZero(countZero)
  );
endmodule

// File: tb/tb_dma_chan_engine.sv
module tb_dma_chan_engine;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        load = 1'b0;
  logic [15:0] baseAddr = '0;
  logic [15:0] baseCount = '0;
  logic [7:0]  pageIn = '0;
  logic        wordMode = 1'b0;
  logic        autoInit = 1'b0;
  logic        addrDown = 1'b0;
  logic        step = 1'b0;
  logic [23:0] physAddr;
  logic [15:0] curCount;
  logic        active;
  logic        termCount;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  dma_chan_engine dut (
    .clk(clk), .rstN(rstN), .load(load), .baseAddr(baseAddr),
    .baseCount(baseCount), .pageIn(pageIn), .wordMode(wordMode),
    .autoInit(autoInit), .addrDown(addrDown), .step(step),
    .physAddr(physAddr), .curCount(curCount), .active(active),
    .termCount(termCount)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic chkState(input string req, input logic [23:0] ePhys, input logic [15:0] eCnt,
                          input logic eAct, input logic eTc);
    chk({req, " physAddr"}, 32'(physAddr), 32'(ePhys));
    chk({req, " curCount"}, 32'(curCount), 32'(eCnt));
    chk({req, " active"}, 32'(active), 32'(eAct));
    chk({req, " termCount"}, 32'(termCount), 32'(eTc));
  endtask

  task automatic doLoad(input logic [15:0] a, input logic [15:0] c, input logic [7:0] p,
                        input logic w, input logic au, input logic dn, input logic withStep);
    @(negedge clk);
    load = 1; baseAddr = a; baseCount = c; pageIn = p;
    wordMode = w; autoInit = au; addrDown = dn; step = withStep;
    @(negedge clk);
    load = 0; step = 0;
  endtask

  task automatic doStep();
    @(negedge clk);
    step = 1;
    @(negedge clk);
    step = 0;
  endtask

  task automatic testReset();
    chkState("R1 reset", 24'h000000, 16'h0000, 1'b0, 1'b0);
  endtask

  task automatic testByteRun();
    doLoad(16'h1234, 16'h0002, 8'h5A, 0, 0, 0, 0);
    chkState("R2 R3 load byte", 24'h5A1234, 16'h0002, 1'b1, 1'b0);
    doStep();
    chkState("R5 step1", 24'h5A1235, 16'h0001, 1'b1, 1'b0);
    doStep();
    chkState("R5 step2", 24'h5A1236, 16'h0000, 1'b1, 1'b0);
    doStep();
    chkState("R8 terminal", 24'h5A1237, 16'hFFFF, 1'b0, 1'b1);
    doStep();
    chkState("R5 R8 ignored after stop", 24'h5A1237, 16'hFFFF, 1'b0, 1'b0);
  endtask

  task automatic testWordMap();
    doLoad(16'h8001, 16'h0005, 8'h5B, 1, 0, 0, 0);
    chkState("R4 word page odd", 24'h5B0002, 16'h0005, 1'b1, 1'b0);
    doLoad(16'h8001, 16'h0005, 8'h5A, 1, 0, 0, 0);
    chkState("R4 word page even", 24'h5B0002, 16'h0005, 1'b1, 1'b0);
    doStep();
    chkState("R4 word step", 24'h5B0004, 16'h0004, 1'b1, 1'b0);
  endtask

  task automatic testWrap();
    doLoad(16'hFFFF, 16'h0003, 8'h12, 0, 0, 0, 0);
    chk("R7 byte pre-wrap", 32'(physAddr), 32'h0012FFFF);
    doStep();
    chkState("R7 byte wrap", 24'h120000, 16'h0002, 1'b1, 1'b0);
    doLoad(16'hFFFF, 16'h0003, 8'h13, 1, 0, 0, 0);
    chk("R7 word pre-wrap", 32'(physAddr), 32'h0013FFFE);
    doStep();
    chkState("R7 word wrap", 24'h120000, 16'h0002, 1'b1, 1'b0);
  endtask

  task automatic testDown();
    doLoad(16'h0000, 16'h0001, 8'h34, 0, 0, 1, 0);
    chkState("R6 load down", 24'h340000, 16'h0001, 1'b1, 1'b0);
    doStep();
    chkState("R6 R7 down wrap", 24'h34FFFF, 16'h0000, 1'b1, 1'b0);
    doStep();
    chkState("R6 R8 down terminal", 24'h34FFFE, 16'hFFFF, 1'b0, 1'b1);
  endtask

  task automatic testSingle();
    doLoad(16'h0010, 16'h0000, 8'h00, 0, 0, 0, 0);
    chkState("R11 load zero count", 24'h000010, 16'h0000, 1'b1, 1'b0);
    doStep();
    chkState("R11 one transfer", 24'h000011, 16'hFFFF, 1'b0, 1'b1);
  endtask

  task automatic testAuto();
    doLoad(16'h0100, 16'h0001, 8'h77, 0, 1, 0, 0);
    doStep();
    chkState("R9 auto step1", 24'h770101, 16'h0000, 1'b1, 1'b0);
    doStep();
    chkState("R9 auto reload", 24'h770100, 16'h0001, 1'b1, 1'b1);
    doStep();
    chkState("R9 auto after reload", 24'h770101, 16'h0000, 1'b1, 1'b0);
  endtask

  task automatic testLoadPriority();
    doLoad(16'h2000, 16'h0004, 8'h09, 0, 0, 0, 0);
    doStep();
    doLoad(16'h4000, 16'h0009, 8'h01, 0, 0, 0, 1);
    chkState("R10 load beats step", 24'h014000, 16'h0009, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testByteRun();
    testWordMap();
    testWrap();
    testDown();
    testSingle();
    testAuto();
    testLoadPriority();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule